// File: doc/BRIEF.md
# Host-Driven FPGA Configuration Sequencer

The sequencer sits between a byte-wide host stream and a target FPGA. In one mode it is a transparent byte pipe to a downstream consumer. In the other mode it drives the target's configuration pins. It powers up in configuration mode and waits for a bitstream. The host can also send it there with a one-cycle configure command.

Incoming bytes must first spell out a fixed 4-byte signature, AA 99 55 66, in that order. When they do, the sequencer:
- pulls the target's active-low program line low for a fixed number of clocks,
- releases it and waits for the target's init-ready input,
- streams the remaining bytes out, either bit-serially or a byte at a time.

The serial or parallel choice is latched when the signature completes. A done indication from the target, or a host exit command, returns the block to pass-through mode. If done does not arrive within a programmable window after the final byte, a timeout flag is raised and the block goes back to waiting for a signature.

Top module: `cfg_seq_top`

## Requirements
- R1: After reset the block is in configuration mode waiting for a signature: `cfg_mode_o`=1, `host_ready_o`=1, `tgt_prog_no`=1, both error flags 0.
- R2: A one-cycle `cmd_cfg_i` pulse in pass-through mode moves the block to signature wait. `cfg_mode_o` becomes 1 and `host_ready_o` becomes 1 regardless of `data_ready_i`.
- R3: A byte that differs from the expected signature byte sets `err_sig_o`. The block stays in signature wait, and matching restarts from the first signature byte (AA).
- R4: After the fourth signature byte (66) is accepted, `tgt_prog_no` is low for exactly PROG_LOW_CYC consecutive cycles. No configuration clock occurs while it is low.
- R5: After the program line is released, `tgt_cclk_o` stays low until `tgt_init_i` is high.
- R6: Serial mode (`mode_par_i`=0 at signature completion) sends each byte MSB first on `tgt_din_o`. Each bit is presented with `tgt_cclk_o` low, and `tgt_cclk_o` is then high for one cycle with the bit unchanged.
- R7: In serial mode `host_ready_o` is 0 while a byte is still being shifted out.
- R8: Parallel mode (`mode_par_i`=1 at signature completion) puts each accepted byte on `tgt_data_o`, with `tgt_cclk_o` high for exactly one cycle per byte, and accepts one byte per clock.
- R9: `mode_par_i` is sampled only when the signature completes. Changing it afterwards has no effect on the current load.
- R10: `tgt_done_i` high during loading or while awaiting done returns the block to pass-through mode (`cfg_mode_o`=0).
- R11: `cmd_exit_i` in any configuration state returns the block to pass-through mode, with `tgt_prog_no`=1.
- R12: If done does not arrive within `done_timeout_i` cycles after the last byte (flagged by `host_last_i`) has been sent, `err_timeout_o` is set and the block returns to signature wait.
- R13: While `cfg_mode_o`=1, `data_valid_o` is 0 and no byte is forwarded.
- R14: In pass-through mode `data_o`/`data_valid_o` follow `host_data_i`/`host_valid_i`, and `host_ready_o` follows `data_ready_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_data_i | input | BYTE_W | Host stream byte |
| host_valid_i | input | 1 | Host byte valid |
| host_last_i | input | 1 | Marks final bitstream byte |
| host_ready_o | output | 1 | Byte accepted when high with valid |
| cmd_cfg_i | input | 1 | Enter configuration (pulse) |
| cmd_exit_i | input | 1 | Force pass-through mode (pulse) |
| mode_par_i | input | 1 | 1 = parallel load, 0 = serial load |
| done_timeout_i | input | TO_W | Cycles allowed for done after last byte |
| data_o | output | BYTE_W | Pass-through byte |
| data_valid_o | output | 1 | Pass-through valid |
| data_ready_i | input | 1 | Downstream ready |
| tgt_prog_no | output | 1 | Target program/reset, active low |
| tgt_init_i | input | 1 | Target init-ready |
| tgt_done_i | input | 1 | Target configuration done |
| tgt_cclk_o | output | 1 | Configuration clock / byte strobe |
| tgt_din_o | output | 1 | Serial configuration data |
| tgt_data_o | output | BYTE_W | Parallel configuration data |
| cfg_mode_o | output | 1 | 1 while in configuration mode |
| err_sig_o | output | 1 | Signature mismatch seen (sticky until next match) |
| err_timeout_o | output | 1 | Done timeout seen (sticky until next match) |

## Verification
The bench builds the block with PROG_LOW_CYC=6 and TO_W=8, and runs with a done window of 20 cycles. The short program pulse keeps the exact low-time count cheap to watch on every cycle. The small window lets a timeout expire in a few dozen cycles, so the error path and the re-entry into signature wait are both reached. The byte width stays at 8, so the serial path is exercised with full MSB-first reconstruction of real byte values.

// File: rtl/cfg_seq_pkg.sv
`timescale 1ns/1ps
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_DATA,
    ST_SIG,
    ST_PROG,
    ST_INIT,
    ST_LOAD,
    ST_DONE
  } seq_state_e;

  localparam int unsigned SIG_BYTES = 4;
  localparam logic [SIG_BYTES*8-1:0] SIG_WORD = 32'hAA995566;
endpackage

// File: rtl/cfg_sig_match.sv
`timescale 1ns/1ps
module cfg_sig_match #(
  parameter int unsigned NBYTES = 4,
  parameter logic [NBYTES*8-1:0] WORD = '0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       hit_o,
  output logic       miss_o
);
  localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

  logic [7:0]       sig_tbl [NBYTES];
  logic [IDX_W-1:0] idx_q;
  logic             match, at_last;

  for (genvar g = 0; g < NBYTES; g++) begin : g_tbl
    assign sig_tbl[g] = WORD[(NBYTES-1-g)*8 +: 8];
  end

  assign match   = (byte_i == sig_tbl[idx_q]);
  assign at_last = (idx_q == IDX_LAST);
  assign hit_o   = byte_vld_i & match & at_last;
  assign miss_o  = byte_vld_i & ~match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_q <= '0;
    else if (clr_i || miss_o) idx_q <= '0;
    else if (byte_vld_i)      idx_q <= at_last ? '0 : idx_q + 1'b1;
  end

  // R3: a mismatch always restarts matching at the first byte
  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |=> (idx_q == '0));
endmodule

// File: rtl/cfg_shift_out.sv
`timescale 1ns/1ps
module cfg_shift_out #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              par_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy_o,
  output logic              cclk_o,
  output logic              din_o,
  output logic [BYTE_W-1:0] pdata_o
);
  localparam int unsigned CW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [CW-1:0] BIT_LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, pd_q;
  logic [CW-1:0]     cnt_q;
  logic              ph_q, busy_q, cclk_q, din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; pd_q <= '0; cnt_q <= '0;
      ph_q <= 1'b0; busy_q <= 1'b0; cclk_q <= 1'b0; din_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0; ph_q <= 1'b0; busy_q <= 1'b0; cclk_q <= 1'b0;
    end else if (load_i) begin
      if (par_i) begin
        pd_q   <= byte_i;
        cclk_q <= 1'b1;
      end else begin
        sh_q   <= {byte_i[BYTE_W-2:0], 1'b0};
        din_q  <= byte_i[BYTE_W-1];
        cnt_q  <= '0;
        ph_q   <= 1'b0;
        busy_q <= 1'b1;
        cclk_q <= 1'b0;
      end
    end else if (busy_q) begin
      if (!ph_q) begin
        cclk_q <= 1'b1;
        ph_q   <= 1'b1;
      end else begin
        cclk_q <= 1'b0;
        ph_q   <= 1'b0;
        if (cnt_q == BIT_LAST) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
          din_q <= sh_q[BYTE_W-1];
          sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
        end
      end
    end else begin
      cclk_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign cclk_o  = cclk_q;
  assign din_o   = din_q;
  assign pdata_o = pd_q;

  // R6: the serial bit does not move during the high phase
  p_din_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cclk_q |-> $stable(din_q));
  // R6: serial clock high for a single cycle per bit
  p_ser_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_i && busy_q && cclk_q) |=> !cclk_q);
endmodule

// File: rtl/cfg_ctrl.sv
`timescale 1ns/1ps
module cfg_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int unsigned PROG_LOW_CYC = 16,
  parameter int unsigned TO_W         = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cmd_cfg_i,
  input  logic            cmd_exit_i,
  input  logic            mode_par_i,
  input  logic            init_i,
  input  logic            done_i,
  input  logic [TO_W-1:0] timeout_i,
  input  logic            sig_hit_i,
  input  logic            sig_miss_i,
  input  logic            load_i,
  input  logic            last_i,
  input  logic            ser_busy_i,
  output seq_state_e      state_o,
  output logic            mode_par_o,
  output logic            last_seen_o,
  output logic            err_sig_o,
  output logic            err_to_o
);
  localparam int unsigned PW    = $clog2(PROG_LOW_CYC + 1);
  localparam int unsigned CNT_W = (TO_W > PW) ? TO_W : PW;
  localparam logic [CNT_W-1:0] PROG_END = CNT_W'(PROG_LOW_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, to_end;
  logic             mode_q, mode_d, last_q, last_d;
  logic             esig_q, esig_d, eto_q, eto_d;

  assign to_end = CNT_W'(timeout_i) - CNT_W'(1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    last_d  = last_q;
    esig_d  = esig_q;
    eto_d   = eto_q;
    if (sig_miss_i) esig_d = 1'b1;
    unique case (state_q)
      ST_DATA: if (cmd_cfg_i) state_d = ST_SIG;
      ST_SIG: if (sig_hit_i) begin
        state_d = ST_PROG;
        cnt_d   = '0;
        mode_d  = mode_par_i;
        esig_d  = 1'b0;
        eto_d   = 1'b0;
      end
      ST_PROG: begin
        if (cnt_q == PROG_END) state_d = ST_INIT;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_INIT: if (init_i) begin
        state_d = ST_LOAD;
        last_d  = 1'b0;
      end
      ST_LOAD: begin
        if (done_i) begin
          state_d = ST_DATA;
        end else begin
          if (load_i && last_i) last_d = 1'b1;
          if (last_q && !ser_busy_i) begin
            state_d = ST_DONE;
            cnt_d   = '0;
          end
        end
      end
      ST_DONE: begin
        if (done_i) begin
          state_d = ST_DATA;
        end else if (cnt_q == to_end) begin
          state_d = ST_SIG;
          eto_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_SIG;
    endcase
    if (cmd_exit_i && state_q != ST_DATA) state_d = ST_DATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SIG;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      last_q  <= 1'b0;
      esig_q  <= 1'b0;
      eto_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mode_q  <= mode_d;
      last_q  <= last_d;
      esig_q  <= esig_d;
      eto_q   <= eto_d;
    end
  end

  assign state_o     = state_q;
  assign mode_par_o  = mode_q;
  assign last_seen_o = last_q;
  assign err_sig_o   = esig_q;
  assign err_to_o    = eto_q;

  p_sig_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_miss_i |=> esig_q);
  p_exit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_exit_i && state_q != ST_DATA) |=> (state_q == ST_DATA));
  p_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_LOAD || state_q == ST_DONE) && done_i) |=> (state_q == ST_DATA));
  p_timeout_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eto_q) |-> (state_q == ST_SIG));
  p_mode_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && state_d == ST_LOAD) |=> $stable(mode_q));
endmodule

// File: rtl/cfg_seq_top.sv
`timescale 1ns/1ps
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int unsigned BYTE_W       = 8,
  parameter int unsigned PROG_LOW_CYC = 16,
  parameter int unsigned TO_W         = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] host_data_i,
  input  logic              host_valid_i,
  input  logic              host_last_i,
  output logic              host_ready_o,
  input  logic              cmd_cfg_i,
  input  logic              cmd_exit_i,
  input  logic              mode_par_i,
  input  logic [TO_W-1:0]   done_timeout_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_valid_o,
  input  logic              data_ready_i,
  output logic              tgt_prog_no,
  input  logic              tgt_init_i,
  input  logic              tgt_done_i,
  output logic              tgt_cclk_o,
  output logic              tgt_din_o,
  output logic [BYTE_W-1:0] tgt_data_o,
  output logic              cfg_mode_o,
  output logic              err_sig_o,
  output logic              err_timeout_o
);
  seq_state_e state;
  logic mode_par, last_seen, ser_busy, sig_hit, sig_miss;
  logic accept, sig_vld, load;

  always_comb begin
    unique case (state)
      ST_DATA: host_ready_o = data_ready_i;
      ST_SIG:  host_ready_o = 1'b1;
      ST_LOAD: host_ready_o = !last_seen && !ser_busy;
      default: host_ready_o = 1'b0;
    endcase
  end

  assign accept  = host_valid_i & host_ready_o;
  assign sig_vld = accept & (state == ST_SIG);
  assign load    = accept & (state == ST_LOAD);

  assign cfg_mode_o   = (state != ST_DATA);
  assign data_valid_o = host_valid_i & (state == ST_DATA);
  assign data_o       = (state == ST_DATA) ? host_data_i : '0;
  assign tgt_prog_no  = (state != ST_PROG);

  cfg_sig_match #(
    .NBYTES (SIG_BYTES),
    .WORD   (SIG_WORD)
  ) u_sig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (state != ST_SIG),
    .byte_vld_i (sig_vld),
    .byte_i     (host_data_i[7:0]),
    .hit_o      (sig_hit),
    .miss_o     (sig_miss)
  );

  cfg_ctrl #(
    .PROG_LOW_CYC (PROG_LOW_CYC),
    .TO_W         (TO_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_cfg_i   (cmd_cfg_i),
    .cmd_exit_i  (cmd_exit_i),
    .mode_par_i  (mode_par_i),
    .init_i      (tgt_init_i),
    .done_i      (tgt_done_i),
    .timeout_i   (done_timeout_i),
    .sig_hit_i   (sig_hit),
    .sig_miss_i  (sig_miss),
    .load_i      (load),
    .last_i      (host_last_i),
    .ser_busy_i  (ser_busy),
    .state_o     (state),
    .mode_par_o  (mode_par),
    .last_seen_o (last_seen),
    .err_sig_o   (err_sig_o),
    .err_to_o    (err_timeout_o)
  );

  cfg_shift_out #(
    .BYTE_W (BYTE_W)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state != ST_LOAD && state != ST_DONE),
    .par_i   (mode_par),
    .load_i  (load),
    .byte_i  (host_data_i),
    .busy_o  (ser_busy),
    .cclk_o  (tgt_cclk_o),
    .din_o   (tgt_din_o),
    .pdata_o (tgt_data_o)
  );

  p_no_cclk_prog_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_cclk_o |-> tgt_prog_no);
  p_init_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_INIT) |-> !tgt_cclk_o);
  p_ser_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_busy && !mode_par) |-> !host_ready_o);
  p_no_fwd_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SIG || state == ST_LOAD) |-> !data_valid_o);
endmodule

// File: tb/tb_cfg_seq_top.sv
`timescale 1ns/1ps
module tb_cfg_seq_top;
  localparam int PROG_LOW = 6;
  localparam int TOW      = 8;
  localparam int TO_VAL   = 20;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] host_data_i = '0;
  logic host_valid_i = 0, host_last_i = 0, cmd_cfg_i = 0, cmd_exit_i = 0;
  logic mode_par_i = 0, data_ready_i = 0, tgt_init_i = 0, tgt_done_i = 0;
  logic [TOW-1:0] done_timeout_i = TOW'(TO_VAL);
  logic host_ready_o, data_valid_o, tgt_prog_no, tgt_cclk_o, tgt_din_o;
  logic cfg_mode_o, err_sig_o, err_timeout_o;
  logic [7:0] data_o, tgt_data_o;

  always #2 clk_i = ~clk_i;

  cfg_seq_top #(.BYTE_W(8), .PROG_LOW_CYC(PROG_LOW), .TO_W(TOW)) dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // target-side monitor
  bit par_exp = 0;
  int prog_low = 0, ev_cnt = 0, bitn = 0, ngot = 0;
  logic [7:0] acc = '0;
  logic [7:0] got [16];
  always @(negedge clk_i) begin
    if (!tgt_prog_no) prog_low++;
    if (tgt_cclk_o) begin
      ev_cnt++;
      if (par_exp) begin
        if (ngot < 16) got[ngot] = tgt_data_o;
        ngot++;
      end else begin
        acc = {acc[6:0], tgt_din_o};
        bitn++;
        if (bitn == 8) begin
          if (ngot < 16) got[ngot] = acc;
          ngot++;
          bitn = 0;
        end
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit l);
    @(negedge clk_i);
    host_data_i = b; host_valid_i = 1; host_last_i = l;
    while (!host_ready_o) @(negedge clk_i);
    @(posedge clk_i); #1;
    host_valid_i = 0; host_last_i = 0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk_i); sig = 1;
    @(posedge clk_i); #1; sig = 0;
  endtask

  task automatic send_sig();
    send(8'hAA, 0); send(8'h99, 0); send(8'h55, 0); send(8'h66, 0);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // data-mode vectors: {data, valid, dready, exp_dvalid, exp_hready}
  localparam int NV = 6;
  localparam logic [11:0] VEC [NV] = '{
    {8'h3C, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'hC3, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'hFF, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h5A, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h81, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1;
    // R1 reset state; R13 no forwarding in signature wait
    @(negedge clk_i); host_valid_i = 1; #1;
    chk("R1 cfg_mode", cfg_mode_o, 1);
    chk("R1 ready", host_ready_o, 1);
    chk("R1 prog_n", tgt_prog_no, 1);
    chk("R1 errs", {err_sig_o, err_timeout_o}, 0);
    chk("R13 dvalid", data_valid_o, 0);
    host_valid_i = 0;

    // R3 bad signature
    send(8'hAA, 0); send(8'h12, 0);
    @(negedge clk_i);
    chk("R3 err_sig", err_sig_o, 1);
    chk("R3 waiting", cfg_mode_o & host_ready_o, 1);

    // good signature, serial; R4 program pulse width
    mode_par_i = 0; par_exp = 0; tgt_init_i = 0;
    prog_low = 0; ev_cnt = 0; ngot = 0; bitn = 0;
    send_sig();
    mode_par_i = 1; // R9: late change ignored
    wait_cyc(PROG_LOW + 25);
    chk("R3 err cleared", err_sig_o, 0);
    chk("R4 prog low cycles", prog_low, PROG_LOW);
    chk("R5 no cclk before init", ev_cnt, 0);
    chk("R5 ready held", host_ready_o, 0);
    tgt_init_i = 1;
    send(8'hA5, 0);
    @(negedge clk_i);
    chk("R7 ready low while shifting", host_ready_o, 0);
    send(8'h3C, 1);
    wait_cyc(24);
    chk("R6 bytes", ngot, 2);
    chk("R6 byte0", got[0], 8'hA5);
    chk("R6 byte1", got[1], 8'h3C);
    chk("R9 serial kept", ev_cnt, 16);
    chk("R10 still cfg", cfg_mode_o, 1);
    @(negedge clk_i); tgt_done_i = 1;
    @(negedge clk_i); tgt_done_i = 0;
    chk("R10 data mode", cfg_mode_o, 0);

    // R14 pass-through table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      host_data_i = VEC[i][11:4]; host_valid_i = VEC[i][3]; data_ready_i = VEC[i][2];
      #1;
      chk("R14 dvalid", data_valid_o, VEC[i][1]);
      chk("R14 ready", host_ready_o, VEC[i][0]);
      if (VEC[i][3]) chk("R14 data", data_o, VEC[i][11:4]);
    end
    host_valid_i = 0; data_ready_i = 0;

    // R2 configure command
    pulse(cmd_cfg_i);
    @(negedge clk_i);
    chk("R2 cfg_mode", cfg_mode_o, 1);
    chk("R2 ready", host_ready_o, 1);

    // parallel load, then R12 timeout
    mode_par_i = 1; par_exp = 1; ev_cnt = 0; ngot = 0;
    send_sig();
    mode_par_i = 0; // R9
    send(8'h11, 0); send(8'hE7, 0); send(8'h42, 1);
    wait_cyc(4);
    chk("R8 bytes", ngot, 3);
    chk("R8 strobes", ev_cnt, 3);
    chk("R8 byte0", got[0], 8'h11);
    chk("R8 byte1", got[1], 8'hE7);
    chk("R8 byte2", got[2], 8'h42);
    wait_cyc(8);
    chk("R12 no early timeout", err_timeout_o, 0);
    wait_cyc(TO_VAL);
    chk("R12 timeout", err_timeout_o, 1);
    chk("R12 back to wait", cfg_mode_o & host_ready_o, 1);

    // R11 exit from signature wait
    pulse(cmd_exit_i);
    @(negedge clk_i);
    chk("R11 exit wait", cfg_mode_o, 0);

    // R11 exit while program line low
    pulse(cmd_cfg_i);
    send_sig();
    wait_cyc(2);
    chk("R11 prog low", tgt_prog_no, 0);
    pulse(cmd_exit_i);
    @(negedge clk_i);
    chk("R11 exit prog", cfg_mode_o, 0);
    chk("R11 prog released", tgt_prog_no, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule